// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits in the issue stage of a multithreaded SIMD core. Each cycle it takes the next two consecutive 64-bit instruction words of the warp the scheduler has picked, together with that warp's pending-write scoreboard. It decides whether the first instruction (slot A) issues, and whether the second (slot B) can issue with it in the same cycle.

Each opcode is sorted into one of five functional classes: integer ALU, floating point, memory, special function or control. Slot B joins slot A only when four conditions all hold. The two classes must differ. Neither instruction may be a control instruction. B must not read or rewrite the register A writes. None of B's registers may be waiting on an outstanding write.

The decision and the decoded fields of both slots are registered, so the issue stage that follows sees them one clock after the words are presented.

Top module: `dual_issue_pair_check`

## Requirements
- R1: The word is split as opcode [63:56], destination [55:48], first source [47:40], second source [39:32], predicate [31:28], third source [27:20] and immediate [19:0]. Each slot presents these raw fields on its outputs.
- R2: Every register comparison and scoreboard lookup uses only the low log2(NUM_REGS) bits of an 8-bit register field. With 64 registers, fields 0x47 and 0x07 name the same register.
- R3: The class output is encoded as ALU=0, FPU=1, LSU=2, SFU=3 and CTRL=4. The opcode ranges are:
  - LSU: 0x10–0x13.
  - FPU: 0x30–0x35, 0x3B–0x3E and 0x54.
  - SFU: 0x40–0x47.
  - CTRL: 0x20–0x28 and 0xFF.
  - ALU: every other opcode, including 0x00 and 0x36–0x3A.
- R4: Slot A issues only when valid_a is high and none of the scoreboard bits for its destination, first source and second source are set. The third source is also looked up when the opcode is 0x05 or 0x35, and only then.
- R5: Slot B never issues in a cycle in which slot A does not issue.
- R6: If either slot holds a control-class instruction, slot B does not issue. Slot A still issues when R4 allows it.
- R7: Two instructions of the same class never issue together. Two different non-control classes do pair when no other rule blocks them.
- R8: Slot B does not issue if its first or second source equals A's destination. The same holds for B's third source, but only when B's opcode is 0x05 or 0x35.
- R9: Slot B does not issue if its destination equals A's destination.
- R10: Slot B issues only when valid_b is high and none of its own scoreboard bits are set. The same register set as in R4 is looked up.
- R11: issue_a, issue_b and all decoded outputs change one clock after the inputs. A synchronous reset drives all of them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_a | input | 1 | Slot A word is present |
| instr_a | input | 64 | First instruction word |
| valid_b | input | 1 | Slot B word is present |
| instr_b | input | 64 | Second instruction word |
| pend_mask | input | NUM_REGS (64) | Scoreboard of the warp: bit n set means register n has a write pending |
| issue_a | output | 1 | Slot A issues |
| issue_b | output | 1 | Slot B issues together with A |
| a_op | output | 8 | Slot A opcode |
| a_rd | output | 8 | Slot A destination field |
| a_rs1 | output | 8 | Slot A first source field |
| a_rs2 | output | 8 | Slot A second source field |
| a_rs3 | output | 8 | Slot A third source field |
| a_pred | output | 4 | Slot A predicate field |
| a_imm | output | 20 | Slot A immediate |
| a_cls | output | 3 | Slot A class code |
| b_op | output | 8 | Slot B opcode |
| b_rd | output | 8 | Slot B destination field |
| b_rs1 | output | 8 | Slot B first source field |
| b_rs2 | output | 8 | Slot B second source field |
| b_rs3 | output | 8 | Slot B third source field |
| b_pred | output | 4 | Slot B predicate field |
| b_imm | output | 20 | Slot B immediate |
| b_cls | output | 3 | Slot B class code |

## Verification
The bench builds the block with NUM_REGS at its default of 64, so register indices are six bits wide and the top two bits of each field are ignored. Some vectors set those top bits on purpose. They show that 0x47 collides with 0x07 and that 0xC1 collides with 0x01, both for pair hazards and for scoreboard lookups. The 64-bit scoreboard also lets the bench place a single pending bit under each register role of either slot. This includes the third source, which counts only for the two three-source opcodes.

// File: rtl/dip_pkg.sv
package dip_pkg;

  localparam int WORD_W   = 64;
  localparam int OP_W     = 8;
  localparam int RF_W     = 8;
  localparam int PRED_W   = 4;
  localparam int IMM_W    = 20;

  localparam int OP_LSB   = 56;
  localparam int RD_LSB   = 48;
  localparam int RS1_LSB  = 40;
  localparam int RS2_LSB  = 32;
  localparam int PRED_LSB = 28;
  localparam int RS3_LSB  = 20;
  localparam int IMM_LSB  = 0;

  typedef enum logic [2:0] {
    CLS_ALU  = 3'd0,
    CLS_FPU  = 3'd1,
    CLS_LSU  = 3'd2,
    CLS_SFU  = 3'd3,
    CLS_CTRL = 3'd4
  } iclass_t;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [RF_W-1:0]   rd;
    logic [RF_W-1:0]   rs1;
    logic [RF_W-1:0]   rs2;
    logic [RF_W-1:0]   rs3;
    logic [PRED_W-1:0] pred;
    logic [IMM_W-1:0]  imm;
    iclass_t           cls;
    logic              use_rs3;
  } dec_t;

  // Sort an opcode into its functional class (R3).
  function automatic iclass_t classify(input logic [OP_W-1:0] op);
    iclass_t c;
    if (op inside {[8'h10:8'h13]})
      c = CLS_LSU;
    else if (op inside {[8'h30:8'h35], [8'h3B:8'h3E], 8'h54})
      c = CLS_FPU;
    else if (op inside {[8'h40:8'h47]})
      c = CLS_SFU;
    else if (op inside {[8'h20:8'h28], 8'hFF})
      c = CLS_CTRL;
    else
      c = CLS_ALU;
    return c;
  endfunction

  // Only the two multiply-add forms read the third source field.
  function automatic logic reads_third(input logic [OP_W-1:0] op);
    return (op == 8'h05) || (op == 8'h35);
  endfunction

endpackage

// File: rtl/dip_decode.sv
module dip_decode
  import dip_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);

  always_comb begin
    dec.op      = word[OP_LSB   +: OP_W];
    dec.rd      = word[RD_LSB   +: RF_W];
    dec.rs1     = word[RS1_LSB  +: RF_W];
    dec.rs2     = word[RS2_LSB  +: RF_W];
    dec.pred    = word[PRED_LSB +: PRED_W];
    dec.rs3     = word[RS3_LSB  +: RF_W];
    dec.imm     = word[IMM_LSB  +: IMM_W];
    dec.cls     = classify(word[OP_LSB +: OP_W]);
    dec.use_rs3 = reads_third(word[OP_LSB +: OP_W]);
  end

endmodule

// File: rtl/dip_sb_probe.sv
module dip_sb_probe #(
  parameter int NUM_REGS = 64,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic [REG_W-1:0]    idx_rd,
  input  logic [REG_W-1:0]    idx_rs1,
  input  logic [REG_W-1:0]    idx_rs2,
  input  logic [REG_W-1:0]    idx_rs3,
  input  logic                use_rs3,
  input  logic [NUM_REGS-1:0] pend,
  output logic                busy
);

  // Any register the instruction touches with a write in flight blocks it.
  always_comb begin
    busy = pend[idx_rd] | pend[idx_rs1] | pend[idx_rs2] |
           (use_rs3 & pend[idx_rs3]);
  end

endmodule

// File: rtl/dip_pair_rules.sv
module dip_pair_rules
  import dip_pkg::*;
#(
  parameter int REG_W = 6
) (
  input  iclass_t          cls_a,
  input  iclass_t          cls_b,
  input  logic [REG_W-1:0] a_rd,
  input  logic [REG_W-1:0] b_rd,
  input  logic [REG_W-1:0] b_rs1,
  input  logic [REG_W-1:0] b_rs2,
  input  logic [REG_W-1:0] b_rs3,
  input  logic             b_use_rs3,
  output logic             pair_ok
);

  logic class_ok;
  logic raw_hit;
  logic waw_hit;

  always_comb begin
    class_ok = (cls_a != CLS_CTRL) && (cls_b != CLS_CTRL) && (cls_a != cls_b);
    raw_hit  = (b_rs1 == a_rd) || (b_rs2 == a_rd) ||
               (b_use_rs3 && (b_rs3 == a_rd));
    waw_hit  = (b_rd == a_rd);
    pair_ok  = class_ok && !raw_hit && !waw_hit;
  end

endmodule

// File: rtl/dual_issue_pair_check.sv
module dual_issue_pair_check
  import dip_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_a,
  input  logic [63:0]         instr_a,
  input  logic                valid_b,
  input  logic [63:0]         instr_b,
  input  logic [NUM_REGS-1:0] pend_mask,
  output logic                issue_a,
  output logic                issue_b,
  output logic [7:0]          a_op,
  output logic [7:0]          a_rd,
  output logic [7:0]          a_rs1,
  output logic [7:0]          a_rs2,
  output logic [7:0]          a_rs3,
  output logic [3:0]          a_pred,
  output logic [19:0]         a_imm,
  output logic [2:0]          a_cls,
  output logic [7:0]          b_op,
  output logic [7:0]          b_rd,
  output logic [7:0]          b_rs1,
  output logic [7:0]          b_rs2,
  output logic [7:0]          b_rs3,
  output logic [3:0]          b_pred,
  output logic [19:0]         b_imm,
  output logic [2:0]          b_cls
);

  localparam int REG_W   = $clog2(NUM_REGS);
  localparam int N_SLOTS = 2;

  logic [WORD_W-1:0] slot_word [N_SLOTS];
  dec_t              slot_dec  [N_SLOTS];
  logic              slot_busy [N_SLOTS];

  assign slot_word[0] = instr_a;
  assign slot_word[1] = instr_b;

  // One decoder and one scoreboard probe per issue slot.
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    dip_decode u_dec (
      .word (slot_word[g]),
      .dec  (slot_dec[g])
    );

    dip_sb_probe #(.NUM_REGS(NUM_REGS)) u_sb (
      .idx_rd  (slot_dec[g].rd[REG_W-1:0]),
      .idx_rs1 (slot_dec[g].rs1[REG_W-1:0]),
      .idx_rs2 (slot_dec[g].rs2[REG_W-1:0]),
      .idx_rs3 (slot_dec[g].rs3[REG_W-1:0]),
      .use_rs3 (slot_dec[g].use_rs3),
      .pend    (pend_mask),
      .busy    (slot_busy[g])
    );
  end

  logic pair_ok;

  dip_pair_rules #(.REG_W(REG_W)) u_rules (
    .cls_a     (slot_dec[0].cls),
    .cls_b     (slot_dec[1].cls),
    .a_rd      (slot_dec[0].rd[REG_W-1:0]),
    .b_rd      (slot_dec[1].rd[REG_W-1:0]),
    .b_rs1     (slot_dec[1].rs1[REG_W-1:0]),
    .b_rs2     (slot_dec[1].rs2[REG_W-1:0]),
    .b_rs3     (slot_dec[1].rs3[REG_W-1:0]),
    .b_use_rs3 (slot_dec[1].use_rs3),
    .pair_ok   (pair_ok)
  );

  logic go_a;
  logic go_b;

  // B is gated by A so program order is never broken.
  always_comb begin
    go_a = valid_a && !slot_busy[0];
    go_b = go_a && valid_b && !slot_busy[1] && pair_ok;
  end

  logic q_issue_a;
  logic q_issue_b;
  dec_t q_dec [N_SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      q_issue_a <= 1'b0;
      q_issue_b <= 1'b0;
      for (int i = 0; i < N_SLOTS; i++) q_dec[i] <= '0;
    end else begin
      q_issue_a <= go_a;
      q_issue_b <= go_b;
      for (int i = 0; i < N_SLOTS; i++) q_dec[i] <= slot_dec[i];
    end
  end

  assign issue_a = q_issue_a;
  assign issue_b = q_issue_b;

  assign a_op   = q_dec[0].op;
  assign a_rd   = q_dec[0].rd;
  assign a_rs1  = q_dec[0].rs1;
  assign a_rs2  = q_dec[0].rs2;
  assign a_rs3  = q_dec[0].rs3;
  assign a_pred = q_dec[0].pred;
  assign a_imm  = q_dec[0].imm;
  assign a_cls  = q_dec[0].cls;

  assign b_op   = q_dec[1].op;
  assign b_rd   = q_dec[1].rd;
  assign b_rs1  = q_dec[1].rs1;
  assign b_rs2  = q_dec[1].rs2;
  assign b_rs3  = q_dec[1].rs3;
  assign b_pred = q_dec[1].pred;
  assign b_imm  = q_dec[1].imm;
  assign b_cls  = q_dec[1].cls;

  // Checks on the registered outputs and the inputs that led to them.
  AST_B_NEEDS_A: assert property (@(posedge clk) disable iff (rst)
    issue_b |-> issue_a);  // R5
  AST_CTRL_ALONE: assert property (@(posedge clk) disable iff (rst)
    issue_b |-> (a_cls != 3'd4 && b_cls != 3'd4));  // R6
  AST_CLASS_DIFF: assert property (@(posedge clk) disable iff (rst)
    issue_b |-> (a_cls != b_cls));  // R7
  AST_NO_RAW: assert property (@(posedge clk) disable iff (rst)
    issue_b |-> (b_rs1[REG_W-1:0] != a_rd[REG_W-1:0] &&
                 b_rs2[REG_W-1:0] != a_rd[REG_W-1:0]));  // R8
  AST_NO_WAW: assert property (@(posedge clk) disable iff (rst)
    issue_b |-> (b_rd[REG_W-1:0] != a_rd[REG_W-1:0]));  // R9
  AST_A_INVALID: assert property (@(posedge clk) disable iff (rst)
    !valid_a |=> !issue_a);  // R4
  AST_SB_STALL: assert property (@(posedge clk) disable iff (rst)
    (valid_a && pend_mask[instr_a[RS1_LSB +: REG_W]]) |=> !issue_a);  // R4
  AST_B_INVALID: assert property (@(posedge clk) disable iff (rst)
    !valid_b |=> !issue_b);  // R10

endmodule

// File: tb/dual_issue_pair_check_test.sv
module dual_issue_pair_check_test;

  localparam int NREG = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_a = 1'b0, valid_b = 1'b0;
  logic [63:0] instr_a = '0, instr_b = '0;
  logic [NREG-1:0] pend_mask = '0;
  logic issue_a, issue_b;
  logic [7:0] a_op, a_rd, a_rs1, a_rs2, a_rs3, b_op, b_rd, b_rs1, b_rs2, b_rs3;
  logic [3:0] a_pred, b_pred;
  logic [19:0] a_imm, b_imm;
  logic [2:0] a_cls, b_cls;

  always #4 clk = ~clk;  // 125 MHz

  dual_issue_pair_check #(.NUM_REGS(NREG)) uut (
    .clk(clk), .rst(rst),
    .valid_a(valid_a), .instr_a(instr_a),
    .valid_b(valid_b), .instr_b(instr_b),
    .pend_mask(pend_mask),
    .issue_a(issue_a), .issue_b(issue_b),
    .a_op(a_op), .a_rd(a_rd), .a_rs1(a_rs1), .a_rs2(a_rs2), .a_rs3(a_rs3),
    .a_pred(a_pred), .a_imm(a_imm), .a_cls(a_cls),
    .b_op(b_op), .b_rd(b_rd), .b_rs1(b_rs1), .b_rs2(b_rs2), .b_rs3(b_rs3),
    .b_pred(b_pred), .b_imm(b_imm), .b_cls(b_cls)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [63:0] mkw(input logic [7:0] op, rd, rs1, rs2, rs3);
    return {op, rd, rs1, rs2, 4'h7, rs3, 20'h0};
  endfunction

  typedef struct packed {
    logic [7:0]  aop, ard, ars1, ars2, ars3;
    logic [7:0]  bop, brd, brs1, brs2, brs3;
    logic        va, vb;
    logic [63:0] sb;
    logic        ea, eb;
    logic [2:0]  ca;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  // Class codes: ALU=0 FPU=1 LSU=2 SFU=3 CTRL=4.
  localparam vec_t VEC [NV] = '{
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b1, 3'd0, 8'd7},  // R7 ALU+FPU
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h02,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd0, 8'd7},  // R7 ALU+ALU
    '{8'h30,8'd1,8'd2,8'd3,8'd4, 8'h32,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd1, 8'd7},  // R7 FPU+FPU
    '{8'h10,8'd1,8'd2,8'd3,8'd4, 8'h13,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd2, 8'd7},  // R7 LSU+LSU
    '{8'h40,8'd1,8'd2,8'd3,8'd4, 8'h45,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd3, 8'd7},  // R7 SFU+SFU
    '{8'h10,8'd1,8'd2,8'd3,8'd4, 8'h40,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b1, 3'd2, 8'd3},  // R3 LSU+SFU
    '{8'h47,8'd1,8'd2,8'd3,8'd4, 8'h3E,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b1, 3'd3, 8'd3},  // R3 SFU+FPU
    '{8'h22,8'd1,8'd2,8'd3,8'd4, 8'h01,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd4, 8'd6},  // R6 ctrl in A
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h20,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd0, 8'd6},  // R6 ctrl in B
    '{8'hFF,8'd1,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd4, 8'd6},  // R6 exit
    '{8'h28,8'd1,8'd2,8'd3,8'd4, 8'h10,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd4, 8'd6},  // R6 top of ctrl range
    '{8'h29,8'd1,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b1, 3'd0, 8'd3},  // R3 0x29 is ALU
    '{8'h36,8'd1,8'd2,8'd3,8'd4, 8'h01,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd0, 8'd3},  // R3 0x36 is ALU
    '{8'h54,8'd1,8'd2,8'd3,8'd4, 8'h01,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b1, 3'd1, 8'd3},  // R3 0x54 is FPU
    '{8'h3B,8'd1,8'd2,8'd3,8'd4, 8'h36,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b1, 3'd1, 8'd3},  // R3 0x3B FPU
    '{8'h00,8'd1,8'd2,8'd3,8'd4, 8'h02,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd0, 8'd3},  // R3 NOP is ALU
    '{8'h01,8'd7,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd7,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd0, 8'd8},  // R8 rs1
    '{8'h01,8'd7,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd7,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd0, 8'd8},  // R8 rs2
    '{8'h01,8'd7,8'd2,8'd3,8'd4, 8'h35,8'd5,8'd6,8'd8,8'd7,  1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd0, 8'd8},  // R8 rs3 read
    '{8'h01,8'd7,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd7,  1'b1,1'b1, 64'h0, 1'b1,1'b1, 3'd0, 8'd8},  // R8 rs3 unused
    '{8'h01,8'd7,8'd2,8'd3,8'd4, 8'h30,8'd7,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd0, 8'd9},  // R9 WAW
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h4, 1'b0,1'b0, 3'd0, 8'd4},  // R4 A rs1 busy
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h2, 1'b0,1'b0, 3'd0, 8'd4},  // R4 A rd busy
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h100, 1'b1,1'b0, 3'd0, 8'd10}, // R10 B rs2 busy
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h20, 1'b1,1'b0, 3'd0, 8'd10},  // R10 B rd busy
    '{8'h05,8'd1,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h10, 1'b0,1'b0, 3'd0, 8'd4},  // R4 IMAD rs3 busy
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h10, 1'b1,1'b1, 3'd0, 8'd4},  // R4 rs3 not read
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b0,1'b1, 64'h0, 1'b0,1'b0, 3'd0, 8'd5},  // R5 A invalid
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b0, 64'h0, 1'b1,1'b0, 3'd0, 8'd10},  // R10 B invalid
    '{8'h01,8'h47,8'd2,8'd3,8'd4, 8'h30,8'd5,8'h07,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd0, 8'd2}, // R2 alias RAW
    '{8'h01,8'd1,8'h42,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h4, 1'b0,1'b0, 3'd0, 8'd2}, // R2 alias sb
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h30,8'hC1,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h0, 1'b1,1'b0, 3'd0, 8'd2}, // R2 alias WAW
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h35,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h400, 1'b1,1'b0, 3'd0, 8'd10}, // R10 FFMA rs3 busy
    '{8'h01,8'd1,8'd2,8'd3,8'd4, 8'h30,8'd5,8'd6,8'd8,8'd10, 1'b1,1'b1, 64'h8, 1'b0,1'b0, 3'd0, 8'd5}   // R5 A stalls, B held
  };

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R11: reset state with valid, pairable inputs applied
    valid_a = 1'b1; valid_b = 1'b1;
    instr_a = mkw(8'h01, 8'd1, 8'd2, 8'd3, 8'd4);
    instr_b = mkw(8'h30, 8'd5, 8'd6, 8'd8, 8'd10);
    repeat (3) @(negedge clk);
    check("R11 reset issue", {62'd0, issue_a, issue_b}, 64'd0);
    check("R11 reset fields", {a_op, b_op, a_rd, b_rd, a_imm, 4'h0}, 64'd0);
    check("R11 reset class", {58'd0, a_cls, b_cls}, 64'd0);
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr_a   = mkw(VEC[i].aop, VEC[i].ard, VEC[i].ars1, VEC[i].ars2, VEC[i].ars3);
      instr_b   = mkw(VEC[i].bop, VEC[i].brd, VEC[i].brs1, VEC[i].brs2, VEC[i].brs3);
      valid_a   = VEC[i].va;
      valid_b   = VEC[i].vb;
      pend_mask = VEC[i].sb;
      @(negedge clk);
      check($sformatf("R%0d vec%0d issue_a", VEC[i].req, i), {63'd0, issue_a}, {63'd0, VEC[i].ea});
      check($sformatf("R%0d vec%0d issue_b", VEC[i].req, i), {63'd0, issue_b}, {63'd0, VEC[i].eb});
      check($sformatf("R3 vec%0d a_cls", i), {61'd0, a_cls}, {61'd0, VEC[i].ca});
    end

    // R1: field extraction on both slots
    @(negedge clk);
    instr_a = {8'h35, 8'h2A, 8'h15, 8'h33, 4'h9, 8'h3C, 20'hABCDE};
    instr_b = {8'h44, 8'h11, 8'h22, 8'h0E, 4'h3, 8'h19, 20'h12345};
    valid_a = 1'b1; valid_b = 1'b1; pend_mask = '0;
    @(negedge clk);
    check("R1 a fields", {a_op, a_rd, a_rs1, a_rs2, a_rs3, a_pred, a_imm}, 64'h352A15333C9ABCDE);
    check("R1 b fields", {b_op, b_rd, b_rs1, b_rs2, b_rs3, b_pred, b_imm}, 64'h4411220E19312345);
    check("R3 b_cls SFU", {61'd0, b_cls}, 64'd3);
    check("R7 FPU+SFU pair", {62'd0, issue_a, issue_b}, 64'd3);

    // R11: outputs hold until the next clock edge
    valid_a = 1'b0;
    #1;
    check("R11 hold before edge", {62'd0, issue_a, issue_b}, 64'd3);
    @(negedge clk);
    check("R11 update after edge", {62'd0, issue_a, issue_b}, 64'd0);

    // R11: synchronous reset mid-run clears registered state
    valid_a = 1'b1;
    @(negedge clk);
    check("R11 issue before reset", {62'd0, issue_a, issue_b}, 64'd3);
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset clears issue", {62'd0, issue_a, issue_b}, 64'd0);
    check("R11 reset clears op", {56'd0, a_op}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    finish_run();
  end

endmodule